// File: doc/BRIEF.md
# USB Host Clock Divider and Gate

This block produces the clock for a USB host port from the output of the second PLL, which is its only source. A small divider scales the PLL output down by one, two or four, so a PLL running at 48, 96 or 192 MHz always yields a 48 MHz port clock. A software-visible enable, driven by separate set and clear strobes, switches the divided clock through to the port. A status bit reads the enable back.

The gated clock only runs while the PLL reports lock. If lock is missing, the output stays low even when software has turned the clock on, and the status bit still shows what software asked for. The divider ratio is registered. A change of the select restarts the divider count from zero. The gate itself is retimed on the falling edge of the PLL clock and only moves while the divided clock is low, so switching the clock on or off never cuts a pulse short.

Top module: `usb_host_clk_gen`

## Requirements
- R1: While reset is asserted and after it is released, the status bit reads 0 and the port clock stays low until a set strobe arrives; the registered ratio starts at divide-by-1.
- R2: Select code 0 gives one port clock cycle per PLL cycle. Code 1 gives one per two PLL cycles. Code 2 gives one per four PLL cycles. A new code is taken at the next PLL rising edge and the divider count restarts from zero.
- R3: The reserved select code 3 divides by four, exactly like code 2.
- R4: A set strobe with no clear strobe makes the status bit read 1 from the next PLL rising edge, and the port clock then runs at the selected ratio.
- R5: A clear strobe makes the status bit read 0 from the next PLL rising edge and stops the port clock. When set and clear arrive in the same cycle, clear wins.
- R6: With neither strobe present, the status bit keeps its value.
- R7: While the lock flag is low, the port clock is low within four PLL cycles, whatever the enable state, and the status bit is not affected. When lock returns, the clock resumes.
- R8: The gate changes only while the divided clock is low. Every high pulse of the port clock therefore lasts exactly half the divided period: 2.5 ns, 5 ns or 10 ns at a 5 ns PLL period for ratios 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pllClk | input | 1 | Second PLL output, the only clock of the block |
| rstN | input | 1 | Asynchronous active-low reset |
| pllLocked | input | 1 | PLL lock flag, synchronous to pllClk |
| divSel | input | 2 | Ratio select: 0 is /1, 1 is /2, 2 is /4, 3 is /4 |
| hostClkSet | input | 1 | One-cycle strobe that turns the port clock on |
| hostClkClr | input | 1 | One-cycle strobe that turns the port clock off |
| usbHostClk | output | 1 | Gated, divided clock for the USB host port |
| hostClkOn | output | 1 | Status: software enable state of the port clock |

## Verification
The assertions assume that the strobes, the lock flag and the ratio select all change synchronously with the PLL clock. They also assume that the select changes only while the port clock is off, because a live switch between the raw PLL clock and a divider tap is not covered by the gate. The bench drives every input one nanosecond after a PLL rising edge. It always clears the enable and waits several cycles before it writes a new select, and it sweeps all four select codes with lock both high and low.

// File: rtl/usb_clk_pkg.sv
package usb_clk_pkg;
  localparam int MAX_SHIFT = 2;
  localparam int SEL_W = 2;
  localparam int SHIFT_W = $clog2(MAX_SHIFT + 1);

  typedef struct packed {
    logic               gateReq;
    logic               restart;
    logic [SHIFT_W-1:0] shift;
  } usbClkCtrl_t;
endpackage

// File: rtl/usbclk_ctrl.sv
module usbclk_ctrl
  import usb_clk_pkg::*;
(
  input  logic             pllClk,
  input  logic             rstN,
  input  logic             pllLocked,
  input  logic [SEL_W-1:0] divSel,
  input  logic             hostClkSet,
  input  logic             hostClkClr,
  output logic             hostEn,
  output usbClkCtrl_t      ctrl
);
  logic [SEL_W-1:0] selReg;

  // enable register: clear has priority over set (R5)
  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) begin
      hostEn <= 1'b0;
      selReg <= '0;
    end else begin
      if (hostClkClr)
        hostEn <= 1'b0;
      else if (hostClkSet)
        hostEn <= 1'b1;
      selReg <= divSel;
    end
  end

  always_comb begin
    ctrl.gateReq = hostEn & pllLocked;
    ctrl.restart = (selReg != divSel);
    // codes above the deepest tap clamp to it (R3)
    if (int'(selReg) > MAX_SHIFT)
      ctrl.shift = SHIFT_W'(MAX_SHIFT);
    else
      ctrl.shift = SHIFT_W'(selReg);
  end
endmodule

// File: rtl/usbclk_datapath.sv
module usbclk_datapath
  import usb_clk_pkg::*;
(
  input  logic        pllClk,
  input  logic        rstN,
  input  usbClkCtrl_t ctrl,
  output logic        divClk,
  output logic        gateOn,
  output logic        usbClk
);
  logic [MAX_SHIFT-1:0] cnt;
  logic [MAX_SHIFT:0]   taps;

  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (ctrl.restart)
      cnt <= '0;
    else
      cnt <= cnt + MAX_SHIFT'(1);
  end

  assign taps[0] = pllClk;
  for (genvar i = 1; i <= MAX_SHIFT; i++) begin : g_tap
    assign taps[i] = cnt[i-1];
  end

  assign divClk = taps[ctrl.shift];

  // gate retimed on the falling edge, moves only while divClk is low (R8)
  always_ff @(negedge pllClk or negedge rstN) begin
    if (!rstN)
      gateOn <= 1'b0;
    else if (!divClk)
      gateOn <= ctrl.gateReq;
  end

  assign usbClk = divClk & gateOn;
endmodule

// File: rtl/usb_host_clk_gen.sv
module usb_host_clk_gen
  import usb_clk_pkg::*;
(
  input  logic             pllClk,
  input  logic             rstN,
  input  logic             pllLocked,
  input  logic [SEL_W-1:0] divSel,
  input  logic             hostClkSet,
  input  logic             hostClkClr,
  output logic             usbHostClk,
  output logic             hostClkOn
);
  usbClkCtrl_t ctrlBus;
  logic        divClkTap;
  logic        gateOnNow;

  usbclk_ctrl u_ctrl (
    .pllClk    (pllClk),
    .rstN      (rstN),
    .pllLocked (pllLocked),
    .divSel    (divSel),
    .hostClkSet(hostClkSet),
    .hostClkClr(hostClkClr),
    .hostEn    (hostClkOn),
    .ctrl      (ctrlBus)
  );

  usbclk_datapath u_dp (
    .pllClk(pllClk),
    .rstN  (rstN),
    .ctrl  (ctrlBus),
    .divClk(divClkTap),
    .gateOn(gateOnNow),
    .usbClk(usbHostClk)
  );
endmodule

// File: rtl/usb_host_clk_gen_chk.sv
module usb_host_clk_gen_chk (
  input logic pllClk,
  input logic rstN,
  input logic pllLocked,
  input logic hostClkSet,
  input logic hostClkClr,
  input logic usbHostClk,
  input logic hostClkOn,
  input logic divClk,
  input logic gateOn
);
  logic [2:0] lockLowCnt;

  always_ff @(negedge pllClk or negedge rstN) begin
    if (!rstN)
      lockLowCnt <= '0;
    else if (pllLocked)
      lockLowCnt <= '0;
    else if (lockLowCnt != 3'd7)
      lockLowCnt <= lockLowCnt + 3'd1;
  end

  always @(posedge pllClk) begin
    if (!rstN) begin
      assert_reset_off_R1: assert (!hostClkOn && !usbHostClk);
    end
  end

  assert_set_on_R4: assert property (@(posedge pllClk) disable iff (!rstN)
    (hostClkSet && !hostClkClr) |=> hostClkOn);

  assert_clr_off_R5: assert property (@(posedge pllClk) disable iff (!rstN)
    hostClkClr |=> !hostClkOn);

  assert_hold_R6: assert property (@(posedge pllClk) disable iff (!rstN)
    (!hostClkSet && !hostClkClr) |=> $stable(hostClkOn));

  assert_lock_low_R7: assert property (@(negedge pllClk) disable iff (!rstN)
    (lockLowCnt >= 3'd4) |-> !usbHostClk);

  always @(gateOn) begin
    if (rstN) begin
      assert_gate_low_R8: assert (divClk == 1'b0);
    end
  end
endmodule

bind usb_host_clk_gen usb_host_clk_gen_chk chk (
  .pllClk    (pllClk),
  .rstN      (rstN),
  .pllLocked (pllLocked),
  .hostClkSet(hostClkSet),
  .hostClkClr(hostClkClr),
  .usbHostClk(usbHostClk),
  .hostClkOn (hostClkOn),
  .divClk    (divClkTap),
  .gateOn    (gateOnNow)
);

// File: tb/usb_host_clk_gen_test.sv
`timescale 1ns/1ps
module usb_host_clk_gen_test;
  logic       pllClk = 1'b0;
  logic       rstN = 1'b0;
  logic       pllLocked = 1'b1;
  logic [1:0] divSel = 2'd0;
  logic       hostClkSet = 1'b0;
  logic       hostClkClr = 1'b0;
  logic       usbHostClk;
  logic       hostClkOn;

  int  total = 0;
  int  bad = 0;
  int  usbEdges = 0;
  int  minHighPs = 1000000;
  realtime riseT = 0.0;

  always #2.5 pllClk = ~pllClk;

  usb_host_clk_gen uut (
    .pllClk(pllClk), .rstN(rstN), .pllLocked(pllLocked), .divSel(divSel),
    .hostClkSet(hostClkSet), .hostClkClr(hostClkClr),
    .usbHostClk(usbHostClk), .hostClkOn(hostClkOn)
  );

  always @(posedge usbHostClk) begin
    usbEdges = usbEdges + 1;
    riseT = $realtime;
  end

  always @(negedge usbHostClk) begin
    int w;
    w = int'(($realtime - riseT) * 1000.0);
    if (w < minHighPs) minHighPs = w;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge pllClk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    usbEdges = 0;
    tick(64);
    n = usbEdges;
  endtask

  task automatic pulseSet();
    hostClkSet = 1'b1; tick(1); hostClkSet = 1'b0;
  endtask

  task automatic pulseClr();
    hostClkClr = 1'b1; tick(1); hostClkClr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    tick(3);
    chk("R1 status in reset", int'(hostClkOn), 0);
    chk("R1 clock in reset", int'(usbHostClk), 0);
    rstN = 1'b1;
    tick(2);
    measure(n);
    chk("R1 no clock after reset", n, 0);
    chk("R1 status after reset", int'(hostClkOn), 0);
    // default ratio is divide-by-1 without any select change
    pulseSet();
    tick(4);
    measure(n);
    chk("R1 default ratio /1", n, 64);
    pulseClr();
    tick(8);

    // sweep every code with lock high and low
    for (int lk = 1; lk >= 0; lk--) begin
      for (int code = 0; code < 4; code++) begin
        int ratio;
        ratio = (code == 0) ? 1 : (code == 1) ? 2 : 4;
        pllLocked = lk[0];
        divSel = code[1:0];
        tick(3);
        minHighPs = 1000000;
        pulseSet();
        chk("R4 status after set", int'(hostClkOn), 1);
        tick(8);
        measure(n);
        if (code == 3)
          chk("R3 reserved code ratio", n, lk != 0 ? 16 : 0);
        else
          chk("R2 ratio edges", n, lk != 0 ? 64 / ratio : 0);
        if (lk == 0)
          chk("R7 status kept with lock low", int'(hostClkOn), 1);
        pulseClr();
        chk("R5 status after clear", int'(hostClkOn), 0);
        tick(8);
        measure(n);
        chk("R5 clock stopped", n, 0);
        if (lk != 0)
          chk("R8 minimum high width ps", minHighPs, ratio * 2500);
      end
    end

    // lock drop while running, then recovery
    pllLocked = 1'b1;
    divSel = 2'd1;
    tick(3);
    pulseSet();
    tick(8);
    pllLocked = 1'b0;
    tick(4);
    chk("R7 low within four cycles", int'(usbHostClk), 0);
    measure(n);
    chk("R7 no clock without lock", n, 0);
    chk("R7 status unaffected", int'(hostClkOn), 1);
    pllLocked = 1'b1;
    tick(8);
    measure(n);
    chk("R7 clock resumes on lock", n, 32);
    pulseClr();
    tick(8);

    // set and clear together: clear wins
    hostClkSet = 1'b1; hostClkClr = 1'b1;
    tick(1);
    hostClkSet = 1'b0; hostClkClr = 1'b0;
    chk("R5 clear beats set", int'(hostClkOn), 0);

    // hold with no strobes
    pulseSet();
    tick(50);
    chk("R6 status held", int'(hostClkOn), 1);
    pulseClr();
    tick(50);
    chk("R6 status held off", int'(hostClkOn), 0);

    // reset in the middle of a run
    divSel = 2'd0;
    tick(3);
    pulseSet();
    tick(8);
    rstN = 1'b0;
    #1;
    chk("R1 status cleared by reset", int'(hostClkOn), 0);
    tick(2);
    measure(n);
    chk("R1 clock held in reset", n, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule